// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that walks a linked chain of transfer descriptors kept in ordinary memory. Software writes one descriptor list and starts the channel with the address of the first entry. After that, no processor help is needed until the last segment has finished. The channel first reads a four-word descriptor. It then copies a block from a source to a destination and follows the descriptor's link word to the next entry. A zero link ends the chain, and the channel then raises a one-cycle completion interrupt.

One memory-master port carries descriptor fetches and data moves. Every data item is read into a one-item holding register and then written out. Either side may be held at a fixed address, which suits a peripheral data register, or may advance by the item width, which suits memory. A control bit selects flow control. With flow control on, the channel moves one burst for each assertion of the peripheral request line. With it off, the channel streams freely, which is the memory-to-memory case.

Top module: `sgdma_chan`

## Requirements
- R1: While reset is applied, and after it is released, `busy`, `irq` and `mem_req` are low until a start is accepted.
- R2: A `start` pulse while idle makes the channel read four 32-bit words at `start_ptr`, +4, +8 and +12, in that order. These words are the source address, the destination address, the control word and the next pointer.
- R3: Control bits [17:16] select the item width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. `mem_size` carries this code on data accesses, and data sits in the low byte lanes. Bits [15:0] give the byte count, and only whole items are moved: size >> width.
- R4: Control bit 24 makes the source address advance by the item width in bytes after each item; bit 25 does the same for the destination. A clear bit keeps that address fixed.
- R5: After the last item, a non-zero next pointer makes the channel fetch that descriptor. A zero next pointer returns it to idle with a single-cycle `irq` pulse.
- R6: With control bit 26 set, no data moves until `dreq` is high. Each high period of `dreq` starts one burst. `dreq` must be seen low again before another burst is taken. The burst length comes from the peripheral side: bits [21:20] if the destination is fixed, otherwise bits [19:18]. The codes 0/1/2/3 mean 1/4/8/16 items.
- R7: A burst never runs past the descriptor: the last burst is cut to the items that remain.
- R8: With control bit 26 clear, items are moved back to back without regard to `dreq`.
- R9: A descriptor whose item count is zero moves no data, and its next pointer is still followed.
- R10: `start` is ignored while the channel is busy.
- R11: A memory request holds its address, direction, size and write data steady until `mem_ready` accepts it.

Control bits [23:22] and [31:27] are unused and should be written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_ptr | input | AW | Address of the first descriptor |
| busy | output | 1 | Channel is working on a chain |
| irq | output | 1 | One-cycle pulse when a chain finishes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_rdata | input | 32 | Read data, low lanes, valid while `mem_ready` is high |
| mem_ready | input | 1 | Accepts the current request this cycle |
| dreq | input | 1 | Peripheral transfer request (level) |

## Verification
The assertions assume that `mem_ready` may stall any request for any number of cycles, and that read data is only meaningful in the accepting cycle. They also assume that descriptors and 32-bit items sit on word-aligned addresses. The bench's memory model inserts a stall in every third cycle and updates read data on the falling edge. All descriptors it builds are word aligned. `dreq` changes only on falling edges and starts low after reset, so each request edge the channel sees is the one the bench intends.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int WORD_W     = 32;
  localparam int SIZE_W     = 16;
  localparam int BEAT_W     = 5;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_LINK
  } sg_state_e;

  typedef struct packed {
    logic              flow;
    logic              dst_inc;
    logic              src_inc;
    logic [1:0]        dst_burst;
    logic [1:0]        src_burst;
    logic [1:0]        width;
    logic [SIZE_W-1:0] size;
  } sg_ctl_t;

  // width code 3 behaves as a full word
  function automatic logic [1:0] eff_width(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return BEAT_W'(1);
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      default: return BEAT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/sgdma_addr_unit.sv
module sgdma_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc_en,
  input  logic [1:0]    width,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_d = addr_q;
    if (load)
      addr_d = load_val;
    else if (step && inc_en)
      addr_d = addr_q + (AW'(1) << width);
  end

  assign addr_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (addr_en)
      addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/sgdma_xfer_cnt.sv
module sgdma_xfer_cnt
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_rem,
  input  logic [SIZE_W-1:0] rem_val,
  input  logic              ld_burst,
  input  logic [BEAT_W-1:0] beats,
  input  logic              dec,
  output logic              last_item,
  output logic              burst_end
);

  logic [SIZE_W-1:0] rem_q, rem_d;
  logic [BEAT_W-1:0] bur_q, bur_d;
  logic              rem_en, bur_en;

  always_comb begin
    rem_d = rem_q;
    if (ld_rem)
      rem_d = rem_val;
    else if (dec)
      rem_d = rem_q - SIZE_W'(1);

    bur_d = bur_q;
    if (ld_burst)
      bur_d = (rem_q < SIZE_W'(beats)) ? rem_q[BEAT_W-1:0] : beats;
    else if (dec)
      bur_d = bur_q - BEAT_W'(1);
  end

  assign rem_en = ld_rem | dec;
  assign bur_en = ld_burst | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      bur_q <= '0;
    end else begin
      if (rem_en) rem_q <= rem_d;
      if (bur_en) bur_q <= bur_d;
    end
  end

  assign last_item = (rem_q == SIZE_W'(1));
  assign burst_end = (bur_q == BEAT_W'(1));

endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  output logic          busy,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          dreq
);

  localparam int SIDES = 2;  // 0 = source, 1 = destination

  sg_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [AW-1:0]     next_q;
  sg_ctl_t           ctl_q;
  logic [WORD_W-1:0] data_q, data_m;
  logic              armed_q, armed_d;
  logic              irq_q, irq_d;

  logic              acc, fetch_acc, rd_acc, wr_acc;
  logic              ld_rem, ld_burst;
  logic              last_item, burst_end;
  logic [1:0]        wsel;
  logic [SIZE_W-1:0] items;
  logic [BEAT_W-1:0] beats_sel;
  logic [SIDES-1:0]  side_load, side_inc;
  logic [AW-1:0]     side_addr [SIDES];

  assign acc       = mem_req & mem_ready;
  assign fetch_acc = acc & (state_q == ST_FETCH);
  assign rd_acc    = acc & (state_q == ST_RD);
  assign wr_acc    = acc & (state_q == ST_WR);

  assign wsel      = eff_width(ctl_q.width);
  assign items     = ctl_q.size >> wsel;
  assign beats_sel = burst_beats(ctl_q.dst_inc ? ctl_q.src_burst : ctl_q.dst_burst);

  assign side_load[0] = fetch_acc & (idx_q == IDX_W'(0));
  assign side_load[1] = fetch_acc & (idx_q == IDX_W'(1));
  assign side_inc     = {ctl_q.dst_inc, ctl_q.src_inc};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    sgdma_addr_unit #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (side_load[g]),
      .load_val (mem_rdata[AW-1:0]),
      .step     (wr_acc),
      .inc_en   (side_inc[g]),
      .width    (wsel),
      .addr     (side_addr[g])
    );
  end

  sgdma_xfer_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_rem    (ld_rem),
    .rem_val   (items),
    .ld_burst  (ld_burst),
    .beats     (beats_sel),
    .dec       (wr_acc),
    .last_item (last_item),
    .burst_end (burst_end)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    ptr_d    = ptr_q;
    irq_d    = 1'b0;
    ld_rem   = 1'b0;
    ld_burst = 1'b0;
    armed_d  = armed_q | ~dreq;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ptr_d   = start_ptr;
          idx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (acc) begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(DESC_WORDS - 1)) state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        ld_rem = 1'b1;
        if (items == '0)   state_d = ST_LINK;
        else if (ctl_q.flow) state_d = ST_WAIT;
        else               state_d = ST_RD;
      end
      ST_WAIT: begin
        if (dreq && armed_q) begin
          ld_burst = 1'b1;
          armed_d  = 1'b0;
          state_d  = ST_RD;
        end
      end
      ST_RD: begin
        if (acc) state_d = ST_WR;
      end
      ST_WR: begin
        if (acc) begin
          if (last_item)                   state_d = ST_LINK;
          else if (ctl_q.flow && burst_end) state_d = ST_WAIT;
          else                             state_d = ST_RD;
        end
      end
      ST_LINK: begin
        if (next_q == '0) begin
          irq_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ptr_d   = next_q;
          idx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // memory port drive
  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    mem_size = 2'd2;
    case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'({idx_q, 2'b00});
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = side_addr[0];
        mem_size = wsel;
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = side_addr[1];
        mem_size = wsel;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (wsel)
      2'd0:    data_m = {24'd0, mem_rdata[7:0]};
      2'd1:    data_m = {16'd0, mem_rdata[15:0]};
      default: data_m = mem_rdata;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      next_q  <= '0;
      ctl_q   <= '0;
      data_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
      if (fetch_acc && idx_q == IDX_W'(2)) begin
        ctl_q.size      <= mem_rdata[15:0];
        ctl_q.width     <= mem_rdata[17:16];
        ctl_q.src_burst <= mem_rdata[19:18];
        ctl_q.dst_burst <= mem_rdata[21:20];
        ctl_q.src_inc   <= mem_rdata[24];
        ctl_q.dst_inc   <= mem_rdata[25];
        ctl_q.flow      <= mem_rdata[26];
      end
      if (fetch_acc && idx_q == IDX_W'(3))
        next_q <= mem_rdata[AW-1:0];
      if (rd_acc)
        data_q <= data_m;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign irq       = irq_q;
  assign mem_wdata = data_q;

endmodule

// File: rtl/sgdma_chan_chk.sv
module sgdma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready
);

  // R11: a stalled request stays unchanged
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_size) && $stable(mem_wdata)));

  // R5: completion interrupt lasts one cycle
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: interrupt only once the channel is idle again
  a_r5_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  // R1: an idle channel issues no memory traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R3: access size is always a legal code
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'd3));

  // R2: word accesses stay word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));

endmodule

bind sgdma_chan sgdma_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .irq       (irq),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/sgdma_chan_tb.sv
module sgdma_chan_tb;

  localparam int          AW     = 32;
  localparam logic [31:0] PER_RX = 32'h0004_0000;
  localparam logic [31:0] PER_TX = 32'h0004_0010;
  localparam int          VEC_N  = 5;
  // {src[19:0], dst[19:0], size[15:0], width[1:0]}
  localparam logic [57:0] VEC [VEC_N] = '{
    {20'h01000, 20'h02000, 16'h0010, 2'd2},
    {20'h01101, 20'h02203, 16'h0007, 2'd0},
    {20'h01202, 20'h02402, 16'h000A, 2'd1},
    {20'h01300, 20'h02600, 16'h0040, 2'd2},
    {20'h01400, 20'h02800, 16'h0006, 2'd2}
  };

  logic          clk, rst_n, start, busy, irq;
  logic [AW-1:0] start_ptr, mem_addr;
  logic          mem_req, mem_we, mem_ready, dreq;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;

  sgdma_chan #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .busy(busy), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dreq(dreq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  wr_mem [logic [31:0]];
  int          tx_n, rd_n, stray, irq_n, viol, pass_n, fail_n, rdy_cnt;
  logic [31:0] tx_first, tx_last, tx_xor, rx_seq;
  logic [31:0] rd_log [4];
  logic        prev_stall, prev_we;
  logic [31:0] prev_addr;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return wr_mem.exists(a) ? wr_mem[a] : pat(a);
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {rd_byte(a + 3), rd_byte(a + 2), rd_byte(a + 1), rd_byte(a)};
  endfunction

  function automatic logic [31:0] ctl(input logic [15:0] sz, input logic [1:0] w,
                                      input logic [1:0] sb, input logic [1:0] db,
                                      input logic si, input logic di, input logic fl);
    return {5'b0, fl, di, si, 2'b00, db, sb, w, sz};
  endfunction

  task automatic put_word(input logic [31:0] a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) wr_mem[a + k] = w[8*k +: 8];
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [31:0] n);
    put_word(at, s); put_word(at + 4, d); put_word(at + 8, c); put_word(at + 12, n);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] p);
    @(negedge clk); start = 1'b1; start_ptr = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output bit got);
    int base;
    base = irq_n; got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq_n != base) begin got = 1'b1; break; end
    end
  endtask

  // memory and peripheral model: inputs change on the falling edge
  always @(negedge clk) begin
    rdy_cnt   <= (rdy_cnt == 2) ? 0 : rdy_cnt + 1;
    mem_ready <= (rdy_cnt != 2);
    mem_rdata <= (mem_addr == PER_RX) ? rx_seq : word_at(mem_addr);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (irq) irq_n++;
      if (prev_stall && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) viol++;
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (mem_addr == PER_TX) begin
            tx_n++;
            if (tx_n == 1) tx_first = mem_wdata;
            tx_last = mem_wdata;
            tx_xor  = tx_xor ^ mem_wdata;
          end else if (mem_addr[31:16] == 16'h0004) begin
            stray++;
          end else begin
            for (int k = 0; k < (1 << mem_size); k++) wr_mem[mem_addr + k] = mem_wdata[8*k +: 8];
          end
        end else begin
          if (rd_n < 4) rd_log[rd_n] = mem_addr;
          rd_n++;
          if (mem_addr == PER_RX) rx_seq = rx_seq + 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    bit got;
    int base, mism;
    logic [31:0] exp_xor, s0;
    pass_n = 0; fail_n = 0; tx_n = 0; rd_n = 0; stray = 0; irq_n = 0; viol = 0;
    rdy_cnt = 0; tx_xor = '0; tx_first = '0; tx_last = '0; rx_seq = 32'h0000_1230;
    prev_stall = 1'b0; prev_we = 1'b0; prev_addr = '0;
    rst_n = 1'b0; start = 1'b0; start_ptr = '0; dreq = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_req, "R1 in reset", {busy, irq, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !irq && !mem_req, "R1 after reset", {busy, irq, mem_req}, 0);

    // table walk: memory-to-memory copies at every width
    for (int r = 0; r < VEC_N; r++) begin
      logic [31:0] s, d, at;
      logic [15:0] sz;
      logic [1:0]  w;
      int          copied;
      s = 32'(VEC[r][57:38]); d = 32'(VEC[r][37:18]);
      sz = VEC[r][17:2]; w = VEC[r][1:0];
      at = 32'h0000_8000 + 32'(r * 16);
      put_desc(at, s, d, ctl(sz, w, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0), 32'h0);
      kick(at);
      wait_irq(2000, got);
      chk(got, "R8 free-running copy completes", 32'(got), 1);
      copied = (int'(sz) >> w) << w;
      mism = 0;
      for (int i = 0; i < copied; i++)
        if (rd_byte(d + 32'(i)) != pat(s + 32'(i))) mism++;
      chk(mism == 0, "R3 copied bytes", 32'(mism), 0);
      chk(!wr_mem.exists(d + 32'(copied)), "R3 byte past end untouched", 32'(copied), 0);
    end

    // two-segment chain into a fixed peripheral register
    put_desc(32'h8100, 32'h0A200, PER_TX, ctl(16'h0C00, 2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0), 32'h8200);
    put_desc(32'h8200, 32'h0B200, PER_TX, ctl(16'h0C00, 2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0), 32'h0);
    exp_xor = '0;
    for (int i = 0; i < 768; i++) exp_xor ^= word_at(32'h0A200 + 32'(4 * i)) ^ word_at(32'h0B200 + 32'(4 * i));
    tx_n = 0; tx_xor = '0; rd_n = 0; stray = 0; base = irq_n;
    kick(32'h8100);
    wait_irq(20000, got);
    chk(got, "R5 chain ends with irq", 32'(got), 1);
    chk(tx_n == 1536, "R5 both segments moved", 32'(tx_n), 1536);
    chk(tx_xor == exp_xor, "R4 data from incrementing source", tx_xor, exp_xor);
    chk(tx_first == word_at(32'h0A200), "R4 first item", tx_first, word_at(32'h0A200));
    chk(stray == 0, "R4 fixed destination", 32'(stray), 0);
    for (int i = 0; i < 4; i++)
      chk(rd_log[i] == 32'h8100 + 32'(4 * i), "R2 descriptor fetch order", rd_log[i], 32'h8100 + 32'(4 * i));
    repeat (20) @(negedge clk);
    chk(irq_n - base == 1, "R5 single irq", 32'(irq_n - base), 1);

    // flow control: one burst per request, truncated final burst
    put_desc(32'h8300, 32'h03000, PER_TX, ctl(16'd24, 2'd2, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1), 32'h0);
    tx_n = 0;
    kick(32'h8300);
    repeat (30) @(negedge clk);
    chk(tx_n == 0, "R6 waits for request", 32'(tx_n), 0);
    dreq = 1'b1;
    repeat (60) @(negedge clk);
    chk(tx_n == 4, "R6 one burst per held request", 32'(tx_n), 4);
    dreq = 1'b0;
    repeat (5) @(negedge clk);
    dreq = 1'b1;
    wait_irq(200, got);
    dreq = 1'b0;
    chk(got, "R7 finishes after short burst", 32'(got), 1);
    chk(tx_n == 6, "R7 last burst truncated", 32'(tx_n), 6);
    chk(tx_last == word_at(32'h03014), "R7 last item", tx_last, word_at(32'h03014));

    // peripheral to memory, source fixed, burst from source side
    put_desc(32'h8400, PER_RX, 32'h05000, ctl(16'd8, 2'd1, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1), 32'h0);
    s0 = rx_seq;
    kick(32'h8400);
    repeat (20) @(negedge clk);
    dreq = 1'b1;
    wait_irq(300, got);
    dreq = 1'b0;
    chk(got, "R6 source-side burst completes", 32'(got), 1);
    mism = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      e = s0 + 32'(i);
      if ({rd_byte(32'h05001 + 32'(2 * i)), rd_byte(32'h05000 + 32'(2 * i))} != e[15:0]) mism++;
    end
    chk(mism == 0, "R4 fixed source halfwords", 32'(mism), 0);
    chk(!wr_mem.exists(32'h05008), "R7 nothing past end", 0, 0);

    // zero-length descriptor in the middle of a chain
    put_desc(32'h8600, 32'h03100, 32'h05100, ctl(16'd0, 2'd2, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0), 32'h8700);
    put_desc(32'h8700, 32'h03200, 32'h05200, ctl(16'd4, 2'd2, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0), 32'h0);
    base = irq_n;
    kick(32'h8600);
    wait_irq(500, got);
    chk(!wr_mem.exists(32'h05100), "R9 empty descriptor moves nothing", 0, 0);
    chk(word_at(32'h05200) == word_at(32'h03200), "R9 chain continues", word_at(32'h05200), word_at(32'h03200));
    chk(irq_n - base == 1, "R9 one irq", 32'(irq_n - base), 1);

    // start while busy
    put_desc(32'h8800, 32'h06000, 32'h06800, ctl(16'd64, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0), 32'h0);
    put_desc(32'h8500, 32'h06000, 32'h07000, ctl(16'd4, 2'd2, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0), 32'h0);
    base = irq_n;
    kick(32'h8800);
    repeat (10) @(negedge clk);
    chk(busy, "R10 channel busy at second start", 32'(busy), 1);
    kick(32'h8500);
    wait_irq(2000, got);
    repeat (50) @(negedge clk);
    chk(!busy, "R10 idle after chain", 32'(busy), 0);
    chk(!wr_mem.exists(32'h07000), "R10 second start ignored", 0, 0);
    chk(irq_n - base == 1, "R10 single completion", 32'(irq_n - base), 1);
    chk(rd_byte(32'h0683F) == pat(32'h0603F), "R10 first chain intact", rd_byte(32'h0683F), pat(32'h0603F));

    chk(viol == 0, "R11 stalled requests held", 32'(viol), 0);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

endmodule